// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a segment:offset memory reference, in the style of a 16-bit real-mode processor, into a linear address. Each request carries a reference kind, a base register choice, an index register choice, a signed displacement and an optional segment override. The caller also supplies the current contents of the segment and pointer registers. The block then chooses the effective segment and forms the 16-bit effective offset. It adds the segment value, shifted left by four, to that offset in an adder 21 bits wide.

The segment shift is done in the wiring. The segment value drives bits [19:4] of the adder and the low four bits are zero, so the register contents are never changed and no upper segment bits are lost. The result comes out in two forms. The first is the full 21-bit sum, which keeps the carry out of bit 19. The second is a 20-bit address that wraps modulo 1 MiB. An address unit in a decode pipeline uses the block to produce the address for each memory access. The default segment follows from the kind of access and from whether the BP register takes part.

All results are registered, so a result appears one cycle after the request. Addressing forms that are not legal are flagged.

Top module: `seg_addr_gen`

## Requirements
- R1: A request on `req_valid` gives `out_valid` high exactly one clock later. A cycle with no request drops `out_valid`, and the result outputs keep their last values.
- R2: `out_lin` is the 21-bit sum of (segment value × 16) and the zero-extended effective offset, with the carry kept. For example, segment FE00h with offset ABBEh gives 108BBEh.
- R3: `out_phys` is the same sum truncated to 20 bits, so it wraps modulo 1 MiB. For example, FE00h:ABBEh gives 08BBEh.
- R4: A code fetch (`req_kind`=0) always uses CS (segment id 1) with `reg_ip` as the offset. The base, index, displacement and override inputs have no effect on it.
- R5: A data operand (`req_kind`=1) has the offset base + index + sign-extended `disp`, wrapped to 16 bits. The base codes are 0 none, 1 BX, 2 BP, 3 SI, 4 DI and 5 SP. The index codes are 0 none, 1 SI and 2 DI. Its default segment is DS (id 3).
- R6: A data operand whose base is BP (code 2), with or without an index, defaults to SS (id 2).
- R7: A stack access (`req_kind`=2) uses SS with the offset `reg_sp` + sign-extended `disp`. The override is ignored.
- R8: A string source (`req_kind`=3) uses DS with offset `reg_si`, and the override may replace DS.
- R9: A string destination (`req_kind`=4) uses ES (id 0) with offset `reg_di`. The override is ignored.
- R10: When `ovr_en` is high, an override code from 0 to 5 replaces the default segment of a data operand or a string source. The codes are ES=0, CS=1, SS=2, DS=3, FS=4 and GS=5. Codes 6 and 7 leave the default in place. FS and GS are never chosen except by an override.
- R11: `out_illegal` is high only for a data operand whose base is SP (code 5).
- R12: After reset, `out_valid`, `out_illegal` and every result output read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 3 | Reference kind: 0 code, 1 data, 2 stack, 3 string source, 4 string destination |
| base_sel | input | 3 | Base register code |
| index_sel | input | 2 | Index register code |
| disp | input | 16 | Signed displacement |
| ovr_en | input | 1 | Segment override present |
| ovr_seg | input | 3 | Override segment id |
| seg_es | input | 16 | ES value |
| seg_cs | input | 16 | CS value |
| seg_ss | input | 16 | SS value |
| seg_ds | input | 16 | DS value |
| seg_fs | input | 16 | FS value |
| seg_gs | input | 16 | GS value |
| reg_bx | input | 16 | BX value |
| reg_bp | input | 16 | BP value |
| reg_si | input | 16 | SI value |
| reg_di | input | 16 | DI value |
| reg_sp | input | 16 | SP value |
| reg_ip | input | 16 | Instruction pointer |
| out_valid | output | 1 | Result valid |
| out_seg_id | output | 3 | Chosen segment id |
| out_offset | output | 16 | Effective offset |
| out_lin | output | 21 | Linear address with carry |
| out_phys | output | 20 | Linear address wrapped to 20 bits |
| out_illegal | output | 1 | Illegal addressing form |

## Verification
The assertions assume that the request fields and register values are steady for the whole cycle in which `req_valid` is sampled. The check of the FS and GS outputs also assumes that an override is only presented together with a request. The bench changes every input only on the falling clock edge and holds it through the next rising edge. It presents overrides only inside request cycles, and during idle cycles it leaves the last request fields in place, so each relation the checker compares to the previous cycle sees a defined value.

// File: rtl/seg_addr_pkg.sv
// Package: shared widths and code values for the segmented address generator.
// Assumes a 16-bit offset space and a shift of four for segment values.
package seg_addr_pkg;
    localparam int OFS_W     = 16;
    localparam int SEG_SHIFT = 4;
    localparam int PHYS_W    = OFS_W + SEG_SHIFT;
    localparam int LIN_W     = PHYS_W + 1;
    localparam int KIND_W    = 3;
    localparam int SEGID_W   = 3;
    localparam int BASE_W    = 3;
    localparam int IDX_W     = 2;

    typedef enum logic [KIND_W-1:0] {
        K_CODE  = 3'd0,
        K_DATA  = 3'd1,
        K_STACK = 3'd2,
        K_SSRC  = 3'd3,
        K_SDST  = 3'd4
    } kind_e;

    typedef enum logic [SEGID_W-1:0] {
        S_ES = 3'd0,
        S_CS = 3'd1,
        S_SS = 3'd2,
        S_DS = 3'd3,
        S_FS = 3'd4,
        S_GS = 3'd5
    } seg_e;

    localparam logic [BASE_W-1:0] B_NONE = 3'd0;
    localparam logic [BASE_W-1:0] B_BX   = 3'd1;
    localparam logic [BASE_W-1:0] B_BP   = 3'd2;
    localparam logic [BASE_W-1:0] B_SI   = 3'd3;
    localparam logic [BASE_W-1:0] B_DI   = 3'd4;
    localparam logic [BASE_W-1:0] B_SP   = 3'd5;

    localparam logic [IDX_W-1:0] X_SI = 2'd1;
    localparam logic [IDX_W-1:0] X_DI = 2'd2;

    localparam logic [SEGID_W-1:0] SEG_LAST = 3'd5;
endpackage

// File: rtl/seg_addr_offset.sv
// Effective offset former: picks the offset source from the reference kind,
// adds base, index and sign-extended displacement with 16-bit wrap, and
// reports whether BP takes part and whether the form is illegal.
// Assumes DISP_W <= OFS_W.
module seg_addr_offset
    import seg_addr_pkg::*;
#(
    parameter int DISP_W = 16
) (
    input  logic [KIND_W-1:0] req_kind,
    input  logic [BASE_W-1:0] base_sel,
    input  logic [IDX_W-1:0]  index_sel,
    input  logic [DISP_W-1:0] disp,
    input  logic [OFS_W-1:0]  reg_bx,
    input  logic [OFS_W-1:0]  reg_bp,
    input  logic [OFS_W-1:0]  reg_si,
    input  logic [OFS_W-1:0]  reg_di,
    input  logic [OFS_W-1:0]  reg_sp,
    input  logic [OFS_W-1:0]  reg_ip,
    output logic [OFS_W-1:0]  offset,
    output logic              uses_bp,
    output logic              illegal
);
    logic [OFS_W-1:0] disp_ext;
    logic [OFS_W-1:0] base_val;
    logic [OFS_W-1:0] idx_val;

    // Sign extension variant chosen by the displacement width.
    generate
        if (DISP_W < OFS_W) begin : g_ext
            assign disp_ext = {{(OFS_W-DISP_W){disp[DISP_W-1]}}, disp};
        end else begin : g_same
            assign disp_ext = disp;
        end
    endgenerate

    // Base register value mux.
    always_comb begin
        case (base_sel)
            B_BX:    base_val = reg_bx;
            B_BP:    base_val = reg_bp;
            B_SI:    base_val = reg_si;
            B_DI:    base_val = reg_di;
            B_SP:    base_val = reg_sp;
            default: base_val = '0;
        endcase
    end

    // Index register value mux.
    always_comb begin
        case (index_sel)
            X_SI:    idx_val = reg_si;
            X_DI:    idx_val = reg_di;
            default: idx_val = '0;
        endcase
    end

    // Offset source by reference kind; sums wrap at 16 bits.
    always_comb begin
        uses_bp = 1'b0;
        illegal = 1'b0;
        case (req_kind)
            K_CODE:  offset = reg_ip;
            K_STACK: offset = reg_sp + disp_ext;
            K_SSRC:  offset = reg_si;
            K_SDST:  offset = reg_di;
            default: begin
                offset  = base_val + idx_val + disp_ext;
                uses_bp = (base_sel == B_BP);
                illegal = (base_sel == B_SP);
            end
        endcase
    end
endmodule

// File: rtl/seg_addr_segsel.sv
// Segment chooser: default segment from reference kind and BP use, then an
// optional override for data operands and string sources; outputs the id
// and the 16-bit segment value. Assumes override codes above 5 are ignored.
module seg_addr_segsel
    import seg_addr_pkg::*;
(
    input  logic [KIND_W-1:0]  req_kind,
    input  logic               uses_bp,
    input  logic               ovr_en,
    input  logic [SEGID_W-1:0] ovr_seg,
    input  logic [OFS_W-1:0]   seg_es,
    input  logic [OFS_W-1:0]   seg_cs,
    input  logic [OFS_W-1:0]   seg_ss,
    input  logic [OFS_W-1:0]   seg_ds,
    input  logic [OFS_W-1:0]   seg_fs,
    input  logic [OFS_W-1:0]   seg_gs,
    output logic [SEGID_W-1:0] seg_id,
    output logic [OFS_W-1:0]   seg_val
);
    logic [SEGID_W-1:0] dflt_id;
    logic               ovr_ok;

    // Default segment by reference kind.
    always_comb begin
        case (req_kind)
            K_CODE:  dflt_id = S_CS;
            K_STACK: dflt_id = S_SS;
            K_SSRC:  dflt_id = S_DS;
            K_SDST:  dflt_id = S_ES;
            default: dflt_id = uses_bp ? S_SS : S_DS;
        endcase
    end

    // Override applies only to overridable kinds and legal codes.
    always_comb begin
        ovr_ok = ovr_en && (ovr_seg <= SEG_LAST) &&
                 (req_kind != K_CODE) && (req_kind != K_STACK) &&
                 (req_kind != K_SDST);
        seg_id = ovr_ok ? ovr_seg : dflt_id;
    end

    // Segment value mux.
    always_comb begin
        case (seg_id)
            S_ES:    seg_val = seg_es;
            S_CS:    seg_val = seg_cs;
            S_SS:    seg_val = seg_ss;
            S_FS:    seg_val = seg_fs;
            S_GS:    seg_val = seg_gs;
            default: seg_val = seg_ds;
        endcase
    end
endmodule

// File: rtl/seg_addr_gen.sv
// Top: segmented linear address generator. Segment value is wired into bits
// [19:4] of a 21-bit adder; results are registered for one-cycle latency.
// Assumes request fields are stable while req_valid is sampled.
module seg_addr_gen
    import seg_addr_pkg::*;
#(
    parameter int DISP_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [KIND_W-1:0]  req_kind,
    input  logic [BASE_W-1:0]  base_sel,
    input  logic [IDX_W-1:0]   index_sel,
    input  logic [DISP_W-1:0]  disp,
    input  logic               ovr_en,
    input  logic [SEGID_W-1:0] ovr_seg,
    input  logic [OFS_W-1:0]   seg_es,
    input  logic [OFS_W-1:0]   seg_cs,
    input  logic [OFS_W-1:0]   seg_ss,
    input  logic [OFS_W-1:0]   seg_ds,
    input  logic [OFS_W-1:0]   seg_fs,
    input  logic [OFS_W-1:0]   seg_gs,
    input  logic [OFS_W-1:0]   reg_bx,
    input  logic [OFS_W-1:0]   reg_bp,
    input  logic [OFS_W-1:0]   reg_si,
    input  logic [OFS_W-1:0]   reg_di,
    input  logic [OFS_W-1:0]   reg_sp,
    input  logic [OFS_W-1:0]   reg_ip,
    output logic               out_valid,
    output logic [SEGID_W-1:0] out_seg_id,
    output logic [OFS_W-1:0]   out_offset,
    output logic [LIN_W-1:0]   out_lin,
    output logic [PHYS_W-1:0]  out_phys,
    output logic               out_illegal
);
    logic [OFS_W-1:0]   eff_ofs;
    logic               uses_bp;
    logic               illegal;
    logic [SEGID_W-1:0] seg_id;
    logic [OFS_W-1:0]   seg_val;
    logic [LIN_W-1:0]   lin_sum;

    seg_addr_offset #(.DISP_W(DISP_W)) u_ofs (
        .req_kind  (req_kind),
        .base_sel  (base_sel),
        .index_sel (index_sel),
        .disp      (disp),
        .reg_bx    (reg_bx),
        .reg_bp    (reg_bp),
        .reg_si    (reg_si),
        .reg_di    (reg_di),
        .reg_sp    (reg_sp),
        .reg_ip    (reg_ip),
        .offset    (eff_ofs),
        .uses_bp   (uses_bp),
        .illegal   (illegal)
    );

    seg_addr_segsel u_seg (
        .req_kind (req_kind),
        .uses_bp  (uses_bp),
        .ovr_en   (ovr_en),
        .ovr_seg  (ovr_seg),
        .seg_es   (seg_es),
        .seg_cs   (seg_cs),
        .seg_ss   (seg_ss),
        .seg_ds   (seg_ds),
        .seg_fs   (seg_fs),
        .seg_gs   (seg_gs),
        .seg_id   (seg_id),
        .seg_val  (seg_val)
    );

    // Wide adder: the shift of the segment is only wiring.
    always_comb begin
        lin_sum = {1'b0, seg_val, {SEG_SHIFT{1'b0}}} +
                  {{(LIN_W-OFS_W){1'b0}}, eff_ofs};
    end

    // Output registers: valid every cycle, data captured on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_seg_id  <= '0;
            out_offset  <= '0;
            out_lin     <= '0;
            out_phys    <= '0;
            out_illegal <= 1'b0;
        end else begin
            out_valid <= req_valid;
            if (req_valid) begin
                out_seg_id  <= seg_id;
                out_offset  <= eff_ofs;
                out_lin     <= lin_sum;
                out_phys    <= lin_sum[PHYS_W-1:0];
                out_illegal <= illegal;
            end
        end
    end
endmodule

// File: rtl/seg_addr_gen_chk.sv
// Checker for seg_addr_gen: relates registered outputs to the request
// inputs of the previous cycle. Bound to the top below.
module seg_addr_gen_chk
    import seg_addr_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [KIND_W-1:0]  req_kind,
    input logic [BASE_W-1:0]  base_sel,
    input logic               ovr_en,
    input logic [OFS_W-1:0]   reg_ip,
    input logic [OFS_W-1:0]   reg_di,
    input logic               out_valid,
    input logic [SEGID_W-1:0] out_seg_id,
    input logic [OFS_W-1:0]   out_offset,
    input logic [LIN_W-1:0]   out_lin,
    input logic               out_illegal
);
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);
    a_r1_idle_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);
    a_r1_hold_offset: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(out_offset) && $stable(out_lin));
    a_r4_code_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == K_CODE) |=>
            (out_seg_id == S_CS) && (out_offset == $past(reg_ip)));
    a_r7_stack_ss: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == K_STACK) |=> (out_seg_id == S_SS));
    a_r9_dest_es: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == K_SDST) |=>
            (out_seg_id == S_ES) && (out_offset == $past(reg_di)));
    a_r10_fs_gs_override: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_seg_id == S_FS || out_seg_id == S_GS)) |->
            $past(ovr_en));
    a_r11_sp_base_flag: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (out_illegal ==
            ($past(req_kind) == K_DATA && $past(base_sel) == B_SP)));
endmodule

bind seg_addr_gen seg_addr_gen_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_kind    (req_kind),
    .base_sel    (base_sel),
    .ovr_en      (ovr_en),
    .reg_ip      (reg_ip),
    .reg_di      (reg_di),
    .out_valid   (out_valid),
    .out_seg_id  (out_seg_id),
    .out_offset  (out_offset),
    .out_lin     (out_lin),
    .out_illegal (out_illegal)
);

// File: tb/seg_addr_gen_test.sv
module seg_addr_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = '0;
    logic [2:0]  base_sel = '0;
    logic [1:0]  index_sel = '0;
    logic [15:0] disp = '0;
    logic        ovr_en = 1'b0;
    logic [2:0]  ovr_seg = '0;
    logic [15:0] seg_es = 16'h1000, seg_cs = 16'hFE00, seg_ss = 16'h2000;
    logic [15:0] seg_ds = 16'h3000, seg_fs = 16'h4000, seg_gs = 16'h5000;
    logic [15:0] reg_bx = 16'h0100, reg_bp = 16'h0200, reg_si = 16'h0010;
    logic [15:0] reg_di = 16'h0020, reg_sp = 16'hFFF0, reg_ip = 16'hABBE;
    logic        out_valid;
    logic [2:0]  out_seg_id;
    logic [15:0] out_offset;
    logic [20:0] out_lin;
    logic [19:0] out_phys;
    logic        out_illegal;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    seg_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .base_sel(base_sel), .index_sel(index_sel), .disp(disp),
        .ovr_en(ovr_en), .ovr_seg(ovr_seg),
        .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
        .seg_fs(seg_fs), .seg_gs(seg_gs),
        .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
        .reg_sp(reg_sp), .reg_ip(reg_ip),
        .out_valid(out_valid), .out_seg_id(out_seg_id), .out_offset(out_offset),
        .out_lin(out_lin), .out_phys(out_phys), .out_illegal(out_illegal)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [20:0] lin_of(input logic [15:0] s, input logic [15:0] o);
        return ({5'd0, s} * 21'd16) + {5'd0, o};
    endfunction

    // Drive one request on the falling edge; return at the next falling edge.
    task automatic send(input logic [2:0] k, input logic [2:0] b, input logic [1:0] x,
                        input logic [15:0] d, input logic oe, input logic [2:0] os);
        req_kind = k; base_sel = b; index_sel = x; disp = d;
        ovr_en = oe; ovr_seg = os; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; ovr_en = 1'b0;
    endtask

    task automatic expect_res(input string req, input logic [2:0] sid,
                              input logic [15:0] sval, input logic [15:0] ofs);
        chk(req, {31'd0, out_valid}, 32'd1);
        chk(req, {29'd0, out_seg_id}, {29'd0, sid});
        chk(req, {16'd0, out_offset}, {16'd0, ofs});
        chk(req, {11'd0, out_lin}, {11'd0, lin_of(sval, ofs)});
        chk(req, {12'd0, out_phys}, {12'd0, lin_of(sval, ofs)} & 32'hFFFFF);
    endtask

    task automatic t_reset;
        chk("R12 valid", {31'd0, out_valid}, 32'd0);
        chk("R12 lin", {11'd0, out_lin}, 32'd0);
        chk("R12 ofs", {16'd0, out_offset}, 32'd0);
        chk("R12 illegal", {31'd0, out_illegal}, 32'd0);
    endtask

    task automatic t_code;
        send(3'd0, 3'd1, 2'd1, 16'h0040, 1'b1, 3'd5);
        expect_res("R4 code", 3'd1, 16'hFE00, 16'hABBE);
        chk("R2 carry lin", {11'd0, out_lin}, 32'h108BBE);
        chk("R3 wrap phys", {12'd0, out_phys}, 32'h08BBE);
    endtask

    task automatic t_data_default;
        send(3'd1, 3'd1, 2'd1, 16'h0005, 1'b0, 3'd0);
        expect_res("R5 bx+si+d", 3'd3, 16'h3000, 16'h0115);
        send(3'd1, 3'd1, 2'd0, 16'hFFFF, 1'b0, 3'd0);
        expect_res("R5 neg disp", 3'd3, 16'h3000, 16'h00FF);
        send(3'd1, 3'd4, 2'd0, 16'hFFF0, 1'b0, 3'd0);
        expect_res("R5 16-bit wrap", 3'd3, 16'h3000, 16'h0010);
        chk("R11 legal form", {31'd0, out_illegal}, 32'd0);
    endtask

    task automatic t_data_bp;
        send(3'd1, 3'd2, 2'd2, 16'h0000, 1'b0, 3'd0);
        expect_res("R6 bp+di", 3'd2, 16'h2000, 16'h0220);
        send(3'd1, 3'd2, 2'd1, 16'h0003, 1'b0, 3'd0);
        expect_res("R6 bp+si+d", 3'd2, 16'h2000, 16'h0213);
        send(3'd1, 3'd2, 2'd0, 16'h0000, 1'b0, 3'd0);
        expect_res("R6 bp", 3'd2, 16'h2000, 16'h0200);
    endtask

    task automatic t_stack;
        send(3'd2, 3'd0, 2'd0, 16'hFFFE, 1'b1, 3'd3);
        expect_res("R7 stack", 3'd2, 16'h2000, 16'hFFEE);
    endtask

    task automatic t_string;
        send(3'd3, 3'd0, 2'd0, 16'h0000, 1'b0, 3'd0);
        expect_res("R8 src ds", 3'd3, 16'h3000, 16'h0010);
        send(3'd3, 3'd0, 2'd0, 16'h0000, 1'b1, 3'd0);
        expect_res("R8 src ovr", 3'd0, 16'h1000, 16'h0010);
        send(3'd4, 3'd0, 2'd0, 16'h0000, 1'b1, 3'd4);
        expect_res("R9 dst es", 3'd0, 16'h1000, 16'h0020);
    endtask

    task automatic t_override;
        send(3'd1, 3'd1, 2'd0, 16'h0000, 1'b1, 3'd4);
        expect_res("R10 fs", 3'd4, 16'h4000, 16'h0100);
        send(3'd1, 3'd2, 2'd0, 16'h0000, 1'b1, 3'd3);
        expect_res("R10 bp ovr ds", 3'd3, 16'h3000, 16'h0200);
        send(3'd1, 3'd1, 2'd0, 16'h0000, 1'b1, 3'd6);
        expect_res("R10 bad code", 3'd3, 16'h3000, 16'h0100);
        send(3'd1, 3'd1, 2'd0, 16'h0000, 1'b1, 3'd5);
        expect_res("R10 gs", 3'd5, 16'h5000, 16'h0100);
    endtask

    task automatic t_illegal;
        send(3'd1, 3'd5, 2'd0, 16'h0000, 1'b0, 3'd0);
        chk("R11 sp base", {31'd0, out_illegal}, 32'd1);
        send(3'd2, 3'd5, 2'd0, 16'h0000, 1'b0, 3'd0);
        chk("R11 stack ok", {31'd0, out_illegal}, 32'd0);
    endtask

    task automatic t_idle_hold;
        logic [20:0] prev;
        send(3'd0, 3'd0, 2'd0, 16'h0000, 1'b0, 3'd0);
        prev = out_lin;
        reg_ip = 16'h1234;
        @(negedge clk);
        chk("R1 idle valid", {31'd0, out_valid}, 32'd0);
        chk("R1 hold lin", {11'd0, out_lin}, {11'd0, prev});
        reg_ip = 16'hABBE;
    endtask

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_code();
        t_data_default();
        t_data_bp();
        t_stack();
        t_string();
        t_override();
        t_illegal();
        t_idle_hold();
        done = 1'b1;
        report();
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
        end
    end
endmodule